// File: doc/BRIEF.md
# Fly-By Direct Memory Access Controller

This block moves words between peripheral devices and memory on a shared system bus without ever holding the data itself. The source drives the data bus while the destination captures it, guided by the strobes and address that the controller puts out. Four channels can each be set up by the processor with a memory start address, a transfer count and a direction. A device starts service by raising its request line. The controller then asks the processor for the bus, and only after the processor grants it does the controller acknowledge the device and run the transfers.

Each transfer is two strobe phases of a fixed length. In the first phase only the source strobe is active. In the second phase the source and destination strobes are active together. Once the count is used up, the controller gives the bus back, marks the channel finished, and raises an interrupt. The interrupt stays up until software reads the status.

Top module: `flyby_dma`

## Requirements
- R1: Each channel holds a memory address, a count and a mode, selected by `cpu_fld` (0 address, 1 count, 2 mode, 3 status) and `cpu_ch`. A write loads the field and a read returns it zero-extended. The mode field has enable in bit 1 and direction in bit 0. All fields are zero after reset.
- R2: When an enabled channel's `dreq` is high and the controller is idle with `hlda` low, `hrq` rises. It stays high without any strobe, address or acknowledge until `hlda` is returned.
- R3: While transfers run, the `dack` bit of the serviced channel is high and every other `dack` bit is low. No `dack` bit is high outside a granted hold.
- R4: Direction 0 (memory to device) asserts `mem_rd` for `STROBE_CYC` cycles, then `mem_rd` together with `io_wr` for `STROBE_CYC` cycles. Direction 1 (device to memory) does the same with `io_rd` first and then `io_rd` together with `mem_wr`.
- R5: A count value C gives exactly C+1 transfers. The addresses run from the start address upward by one, wrapping at the width of `bus_addr`. Afterwards the address register reads start+C+1 and the count register reads all ones.
- R6: `hrq` stays high from the first transfer to the last and drops after the last one. All strobes and acknowledges are then low.
- R7: On completion the channel's terminal-count bit is set, its enable bit clears, and `irq` goes high. A status read returns the terminal-count bits in bit positions 0..3 by channel and clears them all, and `irq` then falls. The bits stay set until that read.
- R8: When several enabled channels request at once, the lowest-numbered channel is served first. The others are served after it finishes.
- R9: Register writes made while `hlda` is high have no effect.
- R10: A channel with enable clear never raises `hrq`, whatever its `dreq` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (a status read clears the terminal-count bits) |
| cpu_ch | input | 2 | Channel select |
| cpu_fld | input | 2 | Field select |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data |
| dreq | input | 4 | Device request lines |
| dack | output | 4 | Device acknowledge lines |
| hrq | output | 1 | Hold request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| bus_addr | output | 16 | Memory address, zero when the bus is not in use |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| irq | output | 1 | Completion interrupt |

## Verification
The checker takes for granted that the processor behaves as a bus owner should. It assumes `hlda` rises only in answer to `hrq`, stays high as long as `hrq` is high, and falls soon after `hrq` falls. It also assumes that a requesting device keeps `dreq` up until it is acknowledged. The bench meets these assumptions with a responder that copies `hrq` onto `hlda` on the falling clock edge; the responder can be held back for a few cycles to exercise the wait for the grant. Devices raise `dreq` before the block starts and drop it only after the block completes.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PH1,
    ST_PH2,
    ST_DONE
  } dma_state_e;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_MODE = 2'd2;
  localparam logic [1:0] FLD_STAT = 2'd3;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    fld,
  input  logic [DW-1:0] wdata,
  input  logic          step_en,
  input  logic          done_en,
  input  logic          stat_clr,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          en_q,
  output logic          tc_q
);
  import flyby_dma_pkg::*;

  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic          dir_d, en_d, tc_d;
  logic          ld;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    en_d   = en_q;
    tc_d   = tc_q;
    if (step_en) begin
      addr_d = addr_q + AW'(1);
      cnt_d  = cnt_q - CW'(1);
    end
    if (wr_en) begin
      case (fld)
        FLD_ADDR: addr_d = wdata[AW-1:0];
        FLD_CNT:  cnt_d  = wdata[CW-1:0];
        FLD_MODE: begin
          dir_d = wdata[0];
          en_d  = wdata[1];
        end
        default: ;
      endcase
    end
    if (stat_clr) tc_d = 1'b0;
    if (done_en) begin
      tc_d = 1'b1;
      en_d = 1'b0;
    end
  end

  assign ld = wr_en | step_en | done_en | stat_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      en_q   <= 1'b0;
      tc_q   <= 1'b0;
    end else if (ld) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      en_q   <= en_d;
      tc_q   <= tc_d;
    end
  end
endmodule

// File: rtl/dma_prio.sv
module dma_prio #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic [CHW-1:0] idx,
  output logic           any
);
  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm #(
  parameter int STROBE_CYC = 2,
  localparam int TW = $clog2(STROBE_CYC) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  input  logic hlda,
  input  logic last,
  output logic take,
  output logic hrq,
  output logic bus_act,
  output logic ph1,
  output logic ph2,
  output logic step,
  output logic done
);
  import flyby_dma_pkg::*;

  dma_state_e state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_end;

  assign tmr_end = (tmr_q == TW'(STROBE_CYC - 1));

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    take    = 1'b0;
    step    = 1'b0;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_any && !hlda) begin
          take    = 1'b1;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (hlda) begin
          state_d = ST_PH1;
          tmr_d   = '0;
        end
      end
      ST_PH1: begin
        if (tmr_end) begin
          state_d = ST_PH2;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      ST_PH2: begin
        if (tmr_end) begin
          step  = 1'b1;
          tmr_d = '0;
          if (last) begin
            done    = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_PH1;
          end
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign ph1     = (state_q == ST_PH1);
  assign ph2     = (state_q == ST_PH2);
  assign bus_act = ph1 | ph2;
  assign hrq     = (state_q == ST_HOLD) | bus_act;
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int NCH        = 4,
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int STROBE_CYC = 2,
  localparam int CHW = $clog2(NCH),
  localparam int DW  = (AW > CW) ? AW : CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_wr,
  input  logic           cpu_rd,
  input  logic [CHW-1:0] cpu_ch,
  input  logic [1:0]     cpu_fld,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           hrq,
  input  logic           hlda,
  output logic [AW-1:0]  bus_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           irq
);
  import flyby_dma_pkg::*;

  logic [AW-1:0]  ch_addr [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  logic [NCH-1:0] ch_dir, ch_en, ch_tc;
  logic [NCH-1:0] eligible;
  logic [CHW-1:0] pick_idx, cur_q;
  logic           pick_any;
  logic           take, bus_act, ph1, ph2, step, done, last;
  logic           stat_clr, dir_cur;

  assign stat_clr = cpu_rd && (cpu_fld == FLD_STAT);
  assign eligible = ch_en & dreq;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_cur;
    assign sel_cur = (cur_q == CHW'(i));
    dma_chan_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cpu_wr && !hlda && (cpu_ch == CHW'(i)) && (cpu_fld != FLD_STAT)),
      .fld      (cpu_fld),
      .wdata    (cpu_wdata),
      .step_en  (step && sel_cur),
      .done_en  (done && sel_cur),
      .stat_clr (stat_clr),
      .addr_q   (ch_addr[i]),
      .cnt_q    (ch_cnt[i]),
      .dir_q    (ch_dir[i]),
      .en_q     (ch_en[i]),
      .tc_q     (ch_tc[i])
    );
    assign dack[i] = bus_act && sel_cur;
  end

  dma_prio #(.NCH(NCH)) u_prio (
    .req (eligible),
    .idx (pick_idx),
    .any (pick_any)
  );

  assign last = (ch_cnt[cur_q] == '0);

  dma_xfer_fsm #(.STROBE_CYC(STROBE_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_any (pick_any),
    .hlda    (hlda),
    .last    (last),
    .take    (take),
    .hrq     (hrq),
    .bus_act (bus_act),
    .ph1     (ph1),
    .ph2     (ph2),
    .step    (step),
    .done    (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else if (take) cur_q <= pick_idx;
  end

  assign dir_cur  = ch_dir[cur_q];
  assign mem_rd   = bus_act & ~dir_cur;
  assign io_wr    = ph2 & ~dir_cur;
  assign io_rd    = bus_act & dir_cur;
  assign mem_wr   = ph2 & dir_cur;
  assign bus_addr = bus_act ? ch_addr[cur_q] : '0;
  assign irq      = |ch_tc;

  always_comb begin
    case (cpu_fld)
      FLD_ADDR: cpu_rdata = DW'(ch_addr[cpu_ch]);
      FLD_CNT:  cpu_rdata = DW'(ch_cnt[cpu_ch]);
      FLD_MODE: cpu_rdata = DW'({ch_en[cpu_ch], ch_dir[cpu_ch]});
      default:  cpu_rdata = DW'(ch_tc);
    endcase
  end
endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hrq,
  input logic           hlda,
  input logic [NCH-1:0] dack,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic           irq
);
  p_hold_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hrq && !hlda) |=> hrq);

  p_bus_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |-> (hrq && hlda));

  p_dack_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> (hrq && hlda));

  p_single_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  p_pair_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> (mem_rd && !io_rd && !mem_wr));

  p_pair_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (io_rd && !mem_rd && !io_wr));

  p_irq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!hrq && !(|dack)));
endmodule

bind flyby_dma flyby_dma_chk #(.NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .hrq    (hrq),
  .hlda   (hlda),
  .dack   (dack),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .io_rd  (io_rd),
  .io_wr  (io_wr),
  .irq    (irq)
);

// File: tb/test_flyby_dma.sv
`timescale 1ns/1ps
module test_flyby_dma;
  localparam int SC = 2;
  localparam int NV = 5;
  localparam logic [1:0]  V_CH   [NV] = '{2'd0, 2'd3, 2'd1, 2'd2, 2'd0};
  localparam logic        V_DIR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [15:0] V_ADDR [NV] = '{16'h0100, 16'hFFFE, 16'h8000, 16'h0040, 16'h1000};
  localparam logic [15:0] V_CNT  [NV] = '{16'd3, 16'd3, 16'd0, 16'd7, 16'd1};

  logic clk, rst_n;
  logic cpu_wr, cpu_rd;
  logic [1:0] cpu_ch, cpu_fld;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic [3:0] dreq, dack;
  logic hrq, hlda, hl_en;
  logic [15:0] bus_addr;
  logic mem_rd, mem_wr, io_rd, io_wr, irq;

  int n_chk, n_fail, cyc;

  flyby_dma #(.STROBE_CYC(SC)) i_flyby_dma (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_ch(cpu_ch),
    .cpu_fld(cpu_fld), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dreq(dreq),
    .dack(dack), .hrq(hrq), .hlda(hlda), .bus_addr(bus_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // processor model: grants the bus one half cycle after the request
  always @(negedge clk) hlda <= hl_en ? hrq : 1'b0;

  // bus monitor
  int m_n, m_pri, m_sec, m_bad_pair, m_bad_dack;
  logic [15:0] m_first, m_last;
  logic [3:0] m_first_dack;
  logic m_sec_prev, m_dir;
  logic [1:0] m_ch;

  always @(negedge clk) begin
    logic sec;
    sec = io_wr | mem_wr;
    if (mem_rd | io_rd) m_pri++;
    if (sec) m_sec++;
    if (sec && !m_sec_prev) begin
      m_n++;
      if (m_n == 1) begin
        m_first = bus_addr;
        m_first_dack = dack;
      end
      m_last = bus_addr;
      if (dack != (4'b1 << m_ch)) m_bad_dack++;
      if (m_dir ? !(io_rd && mem_wr && !mem_rd && !io_wr)
                : !(mem_rd && io_wr && !io_rd && !mem_wr)) m_bad_pair++;
    end
    m_sec_prev = sec;
  end

  task automatic mon_clear(input logic [1:0] ch, input logic dir);
    m_n = 0; m_pri = 0; m_sec = 0; m_bad_pair = 0; m_bad_dack = 0;
    m_first = '0; m_last = '0; m_first_dack = '0; m_sec_prev = 1'b0;
    m_ch = ch; m_dir = dir;
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] ch, input logic [1:0] fld, input logic [15:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_ch = ch; cpu_fld = fld; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] ch, input logic [1:0] fld, output logic [15:0] d);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_ch = ch; cpu_fld = fld;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic wait_release(output logic ok);
    logic seen;
    seen = hrq;
    ok = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (hrq) seen = 1'b1;
      if (seen && !hrq) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic run_block(input logic [1:0] ch, input logic dir, input logic [15:0] a,
                           input logic [15:0] c, input int hold_delay, input logic mid_wr);
    logic ok;
    logic [15:0] rd, saved3;
    int n;
    n = int'(c) + 1;
    cpu_write(ch, 2'd0, a);
    cpu_write(ch, 2'd1, c);
    cpu_write(ch, 2'd2, {14'd0, 1'b1, dir});
    if (mid_wr) begin
      cpu_write(2'd3, 2'd0, 16'h1234);
      cpu_read(2'd3, 2'd0, saved3);
    end
    mon_clear(ch, dir);
    hl_en = (hold_delay == 0);
    @(negedge clk);
    dreq[ch] = 1'b1;
    if (hold_delay > 0) begin
      repeat (hold_delay) @(negedge clk);
      chk(hrq && dack == 4'b0 && !(mem_rd | mem_wr | io_rd | io_wr) && bus_addr == '0,
          "R2 wait for grant", {hrq, dack}, 16'h10);
      hl_en = 1'b1;
    end
    if (mid_wr) begin
      for (int k = 0; k < 20 && !hlda; k++) @(negedge clk);
      cpu_write(2'd3, 2'd0, 16'hBEEF);
      cpu_write(ch, 2'd1, 16'd0);
    end
    wait_release(ok);
    dreq[ch] = 1'b0;
    chk(ok, "R6 hold released", ok, 1);
    chk(!hrq && dack == 4'b0 && !(mem_rd | mem_wr | io_rd | io_wr),
        "R6 bus idle after block", {hrq, dack, mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk(m_n == n, "R5 transfer count", m_n, n);
    chk(m_first == a && m_last == a + c, "R5 address sequence", {m_first, m_last}, {a, a + c});
    chk(m_pri == 2 * SC * n && m_sec == SC * n && m_bad_pair == 0, "R4 strobe pairing",
        {m_pri[7:0], m_sec[7:0], m_bad_pair[7:0]}, {8'(2 * SC * n), 8'(SC * n), 8'd0});
    chk(m_bad_dack == 0, "R3 acknowledge of serviced channel", m_bad_dack, 0);
    chk(irq, "R7 irq on completion", irq, 1);
    cpu_read(ch, 2'd0, rd);
    chk(rd == a + c + 16'd1, "R5 final address", rd, a + c + 16'd1);
    cpu_read(ch, 2'd1, rd);
    chk(rd == 16'hFFFF, "R5 count rolled past zero", rd, 16'hFFFF);
    cpu_read(ch, 2'd2, rd);
    chk(rd == {15'd0, dir}, "R7 enable cleared", rd, {15'd0, dir});
    cpu_read(ch, 2'd3, rd);
    chk(rd == (16'd1 << ch), "R7 status bit", rd, 16'd1 << ch);
    @(negedge clk);
    chk(!irq, "R7 irq cleared by status read", irq, 0);
    if (mid_wr) begin
      cpu_read(2'd3, 2'd0, rd);
      chk(rd == saved3, "R9 write during hold ignored", rd, saved3);
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] rd;
    logic ok;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_ch = '0; cpu_fld = '0;
    cpu_wdata = '0; dreq = '0; hl_en = 1'b1;
    mon_clear(2'd0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(!hrq && dack == 4'b0 && !irq && !(mem_rd | mem_wr | io_rd | io_wr),
        "R6 outputs idle after reset", {hrq, dack, irq}, 0);
    cpu_read(2'd2, 2'd0, rd);
    chk(rd == 16'h0, "R1 address reset value", rd, 0);
    cpu_read(2'd2, 2'd2, rd);
    chk(rd == 16'h0, "R1 mode reset value", rd, 0);
    cpu_write(2'd1, 2'd0, 16'hA5C3);
    cpu_read(2'd1, 2'd0, rd);
    chk(rd == 16'hA5C3, "R1 address readback", rd, 16'hA5C3);

    // table of blocks
    for (int v = 0; v < NV; v++) begin
      run_block(V_CH[v], V_DIR[v], V_ADDR[v], V_CNT[v], 0, 1'b0);
    end

    // grant withheld for a while
    run_block(2'd2, 1'b0, 16'h0300, 16'd2, 6, 1'b0);

    // writes while the bus is held
    run_block(2'd1, 1'b1, 16'h0500, 16'd5, 0, 1'b1);

    // disabled channel
    cpu_write(2'd0, 2'd2, 16'h0000);
    dreq[0] = 1'b1;
    repeat (10) @(negedge clk);
    chk(!hrq && dack == 4'b0, "R10 disabled channel ignored", {hrq, dack}, 0);
    dreq[0] = 1'b0;

    // priority: channels 1 and 2 together
    cpu_write(2'd1, 2'd0, 16'h2000);
    cpu_write(2'd1, 2'd1, 16'd1);
    cpu_write(2'd1, 2'd2, 16'h0002);
    cpu_write(2'd2, 2'd0, 16'h3000);
    cpu_write(2'd2, 2'd1, 16'd0);
    cpu_write(2'd2, 2'd2, 16'h0003);
    mon_clear(2'd1, 1'b0);
    @(negedge clk);
    dreq[1] = 1'b1; dreq[2] = 1'b1;
    wait_release(ok);
    dreq[1] = 1'b0;
    chk(m_first_dack == 4'b0010 && m_n == 2, "R8 lowest channel first",
        {m_first_dack, m_n[3:0]}, {4'b0010, 4'd2});
    mon_clear(2'd2, 1'b1);
    wait_release(ok);
    dreq[2] = 1'b0;
    chk(m_first_dack == 4'b0100 && m_n == 1 && m_first == 16'h3000,
        "R8 second channel served after", {m_first_dack, m_first}, {4'b0100, 16'h3000});
    repeat (5) @(negedge clk);
    chk(irq, "R7 irq held until read", irq, 1);
    cpu_read(2'd0, 2'd3, rd);
    chk(rd == 16'h0006, "R7 both status bits", rd, 16'h0006);
    cpu_read(2'd0, 2'd3, rd);
    chk(rd == 16'h0000 && !irq, "R7 status cleared after read", rd, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule